// File: doc/BRIEF.md
# HDLC Receive Frame Status Classifier

This block sits next to an HDLC receive deframer and turns each finished frame into a status word. The deframer supplies strobes for the opening and closing flag, the data bits that remain after zero removal, and a strobe for the abort pattern. The CRC checker supplies a pass or fail level. Software-independent event lines report receive-abort commands, fast-abort commands and buffer overflow. The block counts the payload bits and records whether every bit was zero. At frame close it raises a one-cycle frame indication, together with a short-frame flag, an error flag and a vector of cause bits.

A frame is short when its bit count does not exceed the CRC width. That width is 16 or 32 bits and is chosen by a mode input. A short frame always carries the error flag, except for an all-zero payload of exactly the CRC width that is closed by a normal flag. The deframing, the CRC arithmetic and the buffer memory sit outside this block.

Top module: `hdlc_rx_frame_status`

## Requirements
- R1: After reset `frame_ind_o`, `short_o`, `err_o` and `cause_o` are all 0, and no frame is open.
- R2: A frame opens on `start_flag_i`. It closes on `end_flag_i`, `abort_pat_i`, `cmd_abort_i` or `fast_abort_i` while open. The status appears in the cycle after the closing strobe, as a single-cycle `frame_ind_o` pulse. Cause bits: [0] FCS bad, [1] length not a multiple of 8, [2] too long, [3] abort pattern, [4] abort command, [5] fast abort, [6] overflow.
- R3: With `crc32_sel_i`=0, a frame with 16 or fewer payload bits reports `short_o`=1.
- R4: With `crc32_sel_i`=1, a frame with 32 or fewer payload bits reports `short_o`=1.
- R5: `short_o` comes with `err_o`=1, except when the payload is all zero, has exactly the CRC width in bits, closes with `end_flag_i`, and has no other cause. In that case `err_o`=0.
- R6: A frame that closes by `end_flag_i`, is not short, and has `crc_ok_i`=0 during the closing cycle sets cause[0] and `err_o`.
- R7: A frame that closes by `end_flag_i`, is not short and not too long, and whose bit count is not a multiple of 8 sets cause[1] and `err_o`.
- R8: A frame that is not short and has more than 8×`max_len_i` bits sets cause[2] and `err_o`. The bit counter saturates and never wraps.
- R9: Closing by `abort_pat_i` sets cause[3] and `err_o`. Such a frame is reported even when it has zero bits, and then it is short.
- R10: Closing by `cmd_abort_i` sets cause[4], and closing by `fast_abort_i` sets cause[5]. Both set `err_o`.
- R11: A `buf_ovf_i` pulse while a frame is open sets cause[6] and `err_o` for that frame.
- R12: Closing strobes and events are ignored while no frame is open. An `end_flag_i` with zero counted bits produces no report.
- R13: `short_o`, `err_o` and `cause_o` are nonzero only while `frame_ind_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_flag_i | input | 1 | Opening flag seen; begins a frame |
| end_flag_i | input | 1 | Closing flag seen |
| abort_pat_i | input | 1 | Abort pattern received; closes the frame |
| bit_vld_i | input | 1 | Payload bit valid after zero removal |
| bit_i | input | 1 | Payload bit value |
| crc_ok_i | input | 1 | CRC check passed, sampled at close |
| crc32_sel_i | input | 1 | 1 selects the 32-bit CRC threshold, 0 the 16-bit threshold |
| max_len_i | input | MAXLEN_W | Largest allowed frame length in bytes |
| cmd_abort_i | input | 1 | Receive-abort command; closes the frame |
| fast_abort_i | input | 1 | Fast-abort command; closes the frame |
| buf_ovf_i | input | 1 | Buffer overflow event |
| frame_ind_o | output | 1 | One-cycle frame-end indication |
| short_o | output | 1 | Short frame |
| err_o | output | 1 | Frame error |
| cause_o | output | 7 | Error cause bits, as listed in R2 |

## Verification
Directed frames sit on the short thresholds in both CRC modes: exactly 16 or 32 zero bits, the same length with a single one bit, and one bit beyond the threshold. These cases separate the all-zero exemption from ordinary short frames and from frames that are merely not octet-aligned. Zero-length and few-bit abort-pattern frames, the two abort commands, overflow, a flag shared between two frames, and strobes outside any frame show how each close source is tagged and ignored. Randomised frames then mix lengths, CRC results, length limits and close sources. A bench function predicts each status word from the requirements alone.

// File: rtl/hdlc_rxs_pkg.sv
package hdlc_rxs_pkg;
   localparam int CAUSE_W  = 7;
   localparam int C_FCS    = 0;
   localparam int C_ODD    = 1;
   localparam int C_LONG   = 2;
   localparam int C_ABPAT  = 3;
   localparam int C_CMDAB  = 4;
   localparam int C_FASTAB = 5;
   localparam int C_OVF    = 6;

   typedef struct packed {
      logic ovf;
      logic fast_ab;
      logic cmd_ab;
      logic abort_pat;
      logic too_long;
      logic odd_len;
      logic fcs_bad;
   } cause_t;
endpackage

// File: rtl/hdlc_rxs_bit_tracker.sv
module hdlc_rxs_bit_tracker #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_i,
   input  logic             close_i,
   input  logic             bit_vld_i,
   input  logic             bit_i,
   output logic             in_frame_o,
   output logic [CNT_W-1:0] count_o,
   output logic             all_zero_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             in_frame_q;
   logic [CNT_W-1:0] count_q;
   logic             allz_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         count_q    <= '0;
         allz_q     <= 1'b1;
      end else if (open_i) begin
         in_frame_q <= 1'b1;
         count_q    <= '0;
         allz_q     <= 1'b1;
      end else if (close_i) begin
         in_frame_q <= 1'b0;
      end else if (in_frame_q && bit_vld_i) begin
         if (count_q != CNT_MAX) count_q <= count_q + 1'b1;
         if (bit_i) allz_q <= 1'b0;
      end
   end

   assign in_frame_o = in_frame_q;
   assign count_o    = count_q;
   assign all_zero_o = allz_q;

   AST_CNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_frame_q) && !$past(open_i)) |-> (count_q >= $past(count_q))); // R8
endmodule

// File: rtl/hdlc_rxs_sticky.sv
module hdlc_rxs_sticky #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic         arm_i,
   input  logic [W-1:0] ev_i,
   output logic [W-1:0] seen_o
);
   logic [W-1:0] seen_q;

   for (genvar g = 0; g < W; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 seen_q[g] <= 1'b0;
         else if (clear_i)           seen_q[g] <= 1'b0;
         else if (arm_i && ev_i[g])  seen_q[g] <= 1'b1;
      end
   end

   assign seen_o = seen_q | (ev_i & {W{arm_i}});
endmodule

// File: rtl/hdlc_rxs_classify.sv
module hdlc_rxs_classify
   import hdlc_rxs_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int MAXLEN_W     = 12,
   parameter bit CRC32_EN     = 1'b1,
   parameter int SHORT16_BITS = 16,
   parameter int SHORT32_BITS = 32
) (
   input  logic [CNT_W-1:0]    count_i,
   input  logic                all_zero_i,
   input  logic                crc32_sel_i,
   input  logic [MAXLEN_W-1:0] max_len_i,
   input  logic                crc_ok_i,
   input  logic                end_flag_i,
   input  logic                abort_pat_i,
   input  logic                cmd_abort_i,
   input  logic                fast_abort_i,
   input  logic                ovf_i,
   output logic                report_o,
   output logic                short_o,
   output logic                err_o,
   output cause_t              cause_o
);
   localparam int LIM_W = MAXLEN_W + 3;

   logic [CNT_W-1:0] thr;
   logic [CNT_W-1:0] long_lim;
   logic             is_short, too_long, normal_end, exempt;
   cause_t           c;

   if (CRC32_EN) begin : g_dual
      assign thr = crc32_sel_i ? CNT_W'(SHORT32_BITS) : CNT_W'(SHORT16_BITS);
   end else begin : g_single
      assign thr = CNT_W'(SHORT16_BITS) | CNT_W'({1'b0, crc32_sel_i & 1'b0});
   end

   assign long_lim   = CNT_W'({max_len_i, 3'b000});

   always_comb begin
      is_short   = (count_i <= thr);
      too_long   = (count_i > long_lim);
      normal_end = end_flag_i && !abort_pat_i && !cmd_abort_i && !fast_abort_i;

      c           = '0;
      c.fcs_bad   = normal_end && !is_short && !crc_ok_i;
      c.odd_len   = normal_end && !is_short && !too_long && (count_i[2:0] != 3'd0);
      c.too_long  = !is_short && too_long;
      c.abort_pat = abort_pat_i;
      c.cmd_ab    = cmd_abort_i;
      c.fast_ab   = fast_abort_i;
      c.ovf       = ovf_i;

      exempt   = is_short && (count_i == thr) && all_zero_i && normal_end && !ovf_i;
      report_o = !(normal_end && (count_i == '0));
      short_o  = is_short;
      err_o    = (is_short && !exempt) || (|c);
      cause_o  = c;
   end

   if (LIM_W > CNT_W) begin : g_bad_width
      $error("counter narrower than the length limit");
   end
endmodule

// File: rtl/hdlc_rx_frame_status.sv
module hdlc_rx_frame_status
   import hdlc_rxs_pkg::*;
#(
   parameter int MAXLEN_W     = 12,
   parameter bit CRC32_EN     = 1'b1,
   parameter int SHORT16_BITS = 16,
   parameter int SHORT32_BITS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_flag_i,
   input  logic                end_flag_i,
   input  logic                abort_pat_i,
   input  logic                bit_vld_i,
   input  logic                bit_i,
   input  logic                crc_ok_i,
   input  logic                crc32_sel_i,
   input  logic [MAXLEN_W-1:0] max_len_i,
   input  logic                cmd_abort_i,
   input  logic                fast_abort_i,
   input  logic                buf_ovf_i,
   output logic                frame_ind_o,
   output logic                short_o,
   output logic                err_o,
   output logic [CAUSE_W-1:0]  cause_o
);
   localparam int CNT_W = MAXLEN_W + 4;

   if (MAXLEN_W < 3) begin : g_bad_maxlen
      $error("MAXLEN_W must be at least 3");
   end
   if (SHORT32_BITS <= SHORT16_BITS) begin : g_bad_thr
      $error("32-bit threshold must exceed 16-bit threshold");
   end

   logic             in_frame, all_zero, close, ovf_seen;
   logic [CNT_W-1:0] count;
   logic             rep, sh, er;
   cause_t           cs;

   assign close = in_frame && (end_flag_i || abort_pat_i || cmd_abort_i || fast_abort_i);

   hdlc_rxs_bit_tracker #(.CNT_W(CNT_W)) u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .open_i     (start_flag_i),
      .close_i    (close),
      .bit_vld_i  (bit_vld_i),
      .bit_i      (bit_i),
      .in_frame_o (in_frame),
      .count_o    (count),
      .all_zero_o (all_zero)
   );

   hdlc_rxs_sticky #(.W(1)) u_ovf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (start_flag_i),
      .arm_i   (in_frame),
      .ev_i    (buf_ovf_i),
      .seen_o  (ovf_seen)
   );

   hdlc_rxs_classify #(
      .CNT_W        (CNT_W),
      .MAXLEN_W     (MAXLEN_W),
      .CRC32_EN     (CRC32_EN),
      .SHORT16_BITS (SHORT16_BITS),
      .SHORT32_BITS (SHORT32_BITS)
   ) u_cls (
      .count_i      (count),
      .all_zero_i   (all_zero),
      .crc32_sel_i  (crc32_sel_i),
      .max_len_i    (max_len_i),
      .crc_ok_i     (crc_ok_i),
      .end_flag_i   (end_flag_i),
      .abort_pat_i  (abort_pat_i),
      .cmd_abort_i  (cmd_abort_i),
      .fast_abort_i (fast_abort_i),
      .ovf_i        (ovf_seen),
      .report_o     (rep),
      .short_o      (sh),
      .err_o        (er),
      .cause_o      (cs)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_ind_o <= 1'b0;
         short_o     <= 1'b0;
         err_o       <= 1'b0;
         cause_o     <= '0;
      end else if (close && rep) begin
         frame_ind_o <= 1'b1;
         short_o     <= sh;
         err_o       <= er;
         cause_o     <= cs;
      end else begin
         frame_ind_o <= 1'b0;
         short_o     <= 1'b0;
         err_o       <= 1'b0;
         cause_o     <= '0;
      end
   end

   AST_FLAGS_WITH_FI: assert property (@(posedge clk) disable iff (!rst_n)
      (short_o || err_o || (|cause_o)) |-> frame_ind_o); // R13
   AST_CAUSE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_ind_o && (|cause_o)) |-> err_o); // R6
   AST_LONG_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      cause_o[C_LONG] |-> !short_o); // R8
   AST_REPORT_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ind_o |-> $past(in_frame)); // R12
   AST_ABPAT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_ind_o && cause_o[C_ABPAT]) |-> err_o); // R9
endmodule

// File: tb/tb_hdlc_rx_frame_status.sv
module tb_hdlc_rx_frame_status;
   localparam int MAXLEN_W = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_flag_i = 0, end_flag_i = 0, abort_pat_i = 0, bit_vld_i = 0, bit_i = 0;
   logic crc_ok_i = 0, crc32_sel_i = 0, cmd_abort_i = 0, fast_abort_i = 0, buf_ovf_i = 0;
   logic [MAXLEN_W-1:0] max_len_i = 12'd8;
   logic frame_ind_o, short_o, err_o;
   logic [6:0] cause_o;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   hdlc_rx_frame_status #(.MAXLEN_W(MAXLEN_W)) dut (
      .clk(clk), .rst_n(rst_n), .start_flag_i(start_flag_i), .end_flag_i(end_flag_i),
      .abort_pat_i(abort_pat_i), .bit_vld_i(bit_vld_i), .bit_i(bit_i), .crc_ok_i(crc_ok_i),
      .crc32_sel_i(crc32_sel_i), .max_len_i(max_len_i), .cmd_abort_i(cmd_abort_i),
      .fast_abort_i(fast_abort_i), .buf_ovf_i(buf_ovf_i), .frame_ind_o(frame_ind_o),
      .short_o(short_o), .err_o(err_o), .cause_o(cause_o)
   );

   task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%b exp=%b", tag, got, exp);
      end
   endtask

   function automatic logic [9:0] observed();
      return {frame_ind_o, short_o, err_o, cause_o};
   endfunction

   // term: 0 end flag, 1 abort pattern, 2 abort command, 3 fast abort
   function automatic logic [9:0] model(input int n, input bit allz, input int term,
                                        input bit crc, input bit ovf, input bit m32, input int ml);
      int  thr;
      bit  sh, normal, tl, ex, er;
      logic [6:0] c;
      thr    = m32 ? 32 : 16;
      sh     = (n <= thr);
      normal = (term == 0);
      if (normal && n == 0) return '0;
      tl   = (n > ml * 8);
      c    = '0;
      c[0] = normal && !sh && !crc;
      c[1] = normal && !sh && !tl && (n % 8 != 0);
      c[2] = !sh && tl;
      c[3] = (term == 1);
      c[4] = (term == 2);
      c[5] = (term == 3);
      c[6] = ovf;
      ex   = sh && (n == thr) && allz && normal && !ovf;
      er   = (sh && !ex) || (c != 0);
      return {1'b1, sh, er, c};
   endfunction

   task automatic send_bits(input int n, input bit zeros, input int ovf_at, inout bit allz);
      for (int i = 0; i < n; i++) begin
         bit b;
         b = zeros ? 1'b0 : 1'($urandom % 2);
         if (b) allz = 0;
         bit_vld_i = 1; bit_i = b; buf_ovf_i = (i == ovf_at);
         @(negedge clk);
      end
      bit_vld_i = 0; bit_i = 0; buf_ovf_i = 0;
   endtask

   task automatic drive_term(input int term, input bit crc);
      crc_ok_i     = crc;
      end_flag_i   = (term == 0);
      abort_pat_i  = (term == 1);
      cmd_abort_i  = (term == 2);
      fast_abort_i = (term == 3);
   endtask

   task automatic clear_term();
      end_flag_i = 0; abort_pat_i = 0; cmd_abort_i = 0; fast_abort_i = 0; crc_ok_i = 0;
   endtask

   task automatic run_frame(input string tag, input int n, input bit zeros, input int term,
                            input bit crc, input int ovf_at, input bit m32, input int ml);
      bit allz;
      allz = 1;
      crc32_sel_i = m32; max_len_i = MAXLEN_W'(ml);
      start_flag_i = 1;
      @(negedge clk);
      start_flag_i = 0;
      send_bits(n, zeros, ovf_at, allz);
      drive_term(term, crc);
      @(negedge clk);
      clear_term();
      check(tag, observed(), model(n, allz, term, crc, (ovf_at >= 0 && ovf_at < n), m32, ml));
      @(negedge clk);
      check({tag, " R2 pulse"}, observed(), '0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R1 reset", observed(), '0);
      rst_n = 1;
      @(negedge clk);
      check("R1 idle", observed(), '0);

      run_frame("R5 crc16 16 zeros exempt", 16, 1, 0, 0, -1, 0, 8);
      run_frame("R3 crc16 12 bits short",   12, 0, 0, 1, -1, 0, 8);
      run_frame("R5 crc16 16 zeros ovf",    16, 1, 0, 1, 3, 0, 8);
      run_frame("R7 crc16 17 zeros",        17, 1, 0, 1, -1, 0, 8);
      run_frame("R6 crc16 24 bits bad fcs", 24, 0, 0, 0, -1, 0, 8);
      run_frame("R4 crc32 24 zeros short",  24, 1, 0, 1, -1, 1, 8);
      run_frame("R5 crc32 32 zeros exempt", 32, 1, 0, 0, -1, 1, 8);
      run_frame("R4 crc32 40 bits good",    40, 0, 0, 1, -1, 1, 8);
      run_frame("R8 too long",              48, 0, 0, 1, -1, 0, 2);
      run_frame("R9 abort pattern 0 bits",   0, 0, 1, 1, -1, 0, 8);
      run_frame("R9 abort pattern 7 bits",   7, 0, 1, 1, -1, 0, 8);
      run_frame("R10 command abort",        40, 0, 2, 1, -1, 0, 8);
      run_frame("R10 fast abort",           40, 0, 3, 1, -1, 1, 8);
      run_frame("R11 overflow",             40, 0, 0, 1, 5, 0, 8);
      run_frame("R12 flag pair no report",   0, 0, 0, 1, -1, 0, 8);

      // R12: strobes with no frame open leave the outputs quiet and the next frame clean
      end_flag_i = 1; abort_pat_i = 1; cmd_abort_i = 1; fast_abort_i = 1; buf_ovf_i = 1;
      bit_vld_i = 1; bit_i = 1;
      @(negedge clk);
      end_flag_i = 0; abort_pat_i = 0; cmd_abort_i = 0; fast_abort_i = 0; buf_ovf_i = 0;
      bit_vld_i = 0; bit_i = 0;
      @(negedge clk);
      check("R12 idle strobes ignored", observed(), '0);
      run_frame("R12 clean frame after idle strobes", 32, 1, 0, 1, -1, 0, 8);

      // R2: closing flag shared with the next opening flag
      begin
         bit az;
         az = 1;
         crc32_sel_i = 0; max_len_i = 12'd8;
         start_flag_i = 1; @(negedge clk); start_flag_i = 0;
         send_bits(24, 0, -1, az);
         drive_term(0, 1); start_flag_i = 1;
         @(negedge clk);
         clear_term(); start_flag_i = 0;
         check("R2 shared flag first", observed(), model(24, az, 0, 1, 0, 0, 8));
         az = 1;
         send_bits(16, 1, -1, az);
         drive_term(0, 1);
         @(negedge clk);
         clear_term();
         check("R5 shared flag second", observed(), model(16, az, 0, 1, 0, 0, 8));
         @(negedge clk);
      end

      for (int k = 0; k < 60; k++) begin
         int n, term, ml, ov;
         bit z, crc, m32;
         m32  = 1'($urandom % 2);
         z    = ($urandom % 4) == 0;
         case ($urandom % 4)
            0: n = m32 ? 32 : 16;
            1: n = m32 ? 33 : 17;
            default: n = int'($urandom % 73);
         endcase
         term = (($urandom % 3) == 0) ? int'($urandom % 4) : 0;
         crc  = 1'($urandom % 2);
         ml   = 3 + int'($urandom % 7);
         ov   = (($urandom % 5) == 0 && n > 0) ? int'($urandom % n) : -1;
         run_frame("R8 random frame", n, z, term, crc, ov, m32, ml);
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule